// File: doc/BRIEF.md
# Configuration Address Translator

This block sits behind the CPU decode of a 512 KB configuration window and turns each access into a type-0 configuration request on a simple downstream port. The upper half of a 32-bit configuration address comes from a 16-bit field of a static map register. The lower half is the low 16 bits of the CPU offset. From that address the block picks a one-hot device select field in bits [31:11], a function number in bits [10:8] and a register number in bits [7:2]. It then drives a PCI-style configuration address that carries the enable bit, a static bus number and a device number.

The CPU side presents one request at a time: a byte, halfword or word, read or write. It receives a one-cycle done pulse that carries right-justified read data. A request is answered locally, with no downstream request, in three cases: the map register asks for type-1 (bit 16 set), the device select field is zero, or the access is misaligned. In those cases writes vanish and reads return all ones of the access width. For every request that is forwarded, the block pulses a clear mask for the two received-abort bits of the host's 16-bit status register.

Top module: `cfg_window_xlate`

## Requirements
- R1: After reset, cpuReady is 1 and cpuDone, dsValid, idselErr and statusClr are all 0.
- R2: For a forwarded access, let cfg = {mapCfg[15:0], cpuAddr[15:0]}. dsAddr is then bit 31 = 1, bits [30:24] = 0, bits [23:16] = busNum, bits [15:11] = index of the lowest set bit of cfg[31:11] (bit 11 gives 0), bits [10:8] = cfg[10:8], bits [7:2] = cfg[7:2] and bits [1:0] = 0.
- R3: cpuSize encodes 0 = byte, 1 = halfword, 2 or 3 = word. dsByteEn is 4'b0001 << cpuAddr[1:0] for a byte, 4'b0011 << cpuAddr[1:0] for a halfword and 4'b1111 for a word.
- R4: dsWe equals cpuWe. dsWdata is cpuWdata masked to the access width (0xFF, 0xFFFF or all 32 bits) and shifted left by 8*cpuAddr[1:0].
- R5: A forwarded read returns cpuRdata = (dsRdata >> 8*cpuAddr[1:0]) masked to the access width. The data is taken in the cycle after the dsValid/dsReady handshake, and cpuDone is asserted in the cycle after that.
- R6: When mapCfg[16] is 1, no downstream request is made. A read returns 0xFF, 0xFFFF or 0xFFFFFFFF for a byte, halfword or word, and idselErr is left unchanged.
- R7: When mapCfg[16] is 0 and cfg[31:11] is zero, no downstream request is made, reads return all ones of the width, and idselErr becomes 1 and stays 1 until reset.
- R8: A halfword with cpuAddr[0] = 1, or a word with cpuAddr[1:0] != 0, is answered like R6: no request and all-ones read data.
- R9: statusClr is 16'h3000 (bit 13 clears received master abort, bit 12 clears received target abort) for exactly the one cycle after each downstream handshake. It is 0 at all other times.
- R10: Once dsValid is raised, it stays high with dsAddr and dsByteEn stable until dsReady is sampled high. cpuReady is 0 from acceptance until cpuDone.
- R11: cpuDone is a single-cycle pulse. A request answered locally raises it in the second cycle after the edge that accepts the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | Request, taken on an edge where cpuReady is high |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuSize | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| cpuAddr | input | 16 | Low 16 bits of the offset within the window |
| cpuWdata | input | 32 | Write data, right-justified |
| cpuReady | output | 1 | Block idle and able to take a request |
| cpuDone | output | 1 | One-cycle completion pulse |
| cpuRdata | output | 32 | Read data, right-justified, valid with cpuDone |
| mapCfg | input | 17 | [15:0] upper config address half, [16] type-1 request |
| busNum | input | 8 | Static bus number placed in the config address |
| idselErr | output | 1 | Sticky flag: a zero device select field was seen |
| statusClr | output | 16 | Clear mask for the host status register |
| dsValid | output | 1 | Downstream request valid |
| dsWe | output | 1 | Downstream write |
| dsAddr | output | 32 | Downstream configuration address |
| dsByteEn | output | 4 | Downstream byte enables |
| dsWdata | output | 32 | Downstream lane-aligned write data |
| dsReady | input | 1 | Downstream accepts the request |
| dsRdata | input | 32 | Downstream read data, valid the cycle after dsReady |

## Verification
A wrong device number or a wrong field extraction shows on dsAddr in the same cycle that dsValid rises. It is compared before the handshake completes. A wrong decision to reject or to forward shows within two cycles of acceptance: either a dsValid appears when none should, or a done pulse with all-ones data arrives. A bad lane shift shows in dsByteEn and dsWdata at once, and in cpuRdata at the done pulse. A lost sticky error shows in idselErr after the access that follows.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 16;
  localparam int CFG_W     = 32;
  localparam int MAP_W     = CFG_W - ADDR_W + 1;
  localparam int BUS_W     = 8;
  localparam int IDSEL_LSB = 11;
  localparam int IDSEL_W   = CFG_W - IDSEL_LSB;
  localparam int DEV_W     = $clog2(IDSEL_W);
  localparam int BE_W      = DATA_W / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } accSize_t;

  typedef struct packed {
    logic load;
    logic rejLoad;
    logic capRead;
  } strobe_t;

  function automatic logic [DEV_W-1:0] lowestSet(input logic [IDSEL_W-1:0] v);
    logic [DEV_W-1:0] idx;
    idx = '0;
    for (int i = IDSEL_W - 1; i >= 0; i--) begin
      if (v[i]) idx = DEV_W'(i);
    end
    return idx;
  endfunction

  function automatic logic [DATA_W-1:0] widthMask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return DATA_W'(32'h0000_00FF);
      SZ_HALF: return DATA_W'(32'h0000_FFFF);
      default: return '1;
    endcase
  endfunction
endpackage

// File: rtl/cfgx_dp.sv
module cfgx_dp
  import cfgx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [ADDR_W-1:0]    cpuAddr,
  input  logic [1:0]           cpuSize,
  input  logic                 cpuWe,
  input  logic [DATA_W-1:0]    cpuWdata,
  input  logic [MAP_W-1:0]     mapCfg,
  input  logic [BUS_W-1:0]     busNum,
  input  logic [DATA_W-1:0]    dsRdata,
  output logic [CFG_W-1:0]     dsAddr,
  output logic [BE_W-1:0]      dsByteEn,
  output logic [DATA_W-1:0]    dsWdata,
  output logic                 dsWe,
  output logic [DATA_W-1:0]    rdata,
  output logic                 reject,
  output logic                 idselErr
);
  logic [ADDR_W-1:0]  addrQ;
  logic [1:0]         sizeQ;
  logic               weQ;
  logic [DATA_W-1:0]  wdataQ;
  logic [MAP_W-1:0]   mapQ;
  logic [DATA_W-1:0]  rdataQ;
  logic               errQ;

  logic [CFG_W-1:0]   cfgAddr;
  logic [IDSEL_W-1:0] idsel;
  logic [DEV_W-1:0]   devNum;
  logic               type1;
  logic               idselZero;
  logic               misalign;
  logic [4:0]         laneShift;
  logic [DATA_W-1:0]  mask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      sizeQ  <= '0;
      weQ    <= 1'b0;
      wdataQ <= '0;
      mapQ   <= '0;
    end else if (strb.load) begin
      addrQ  <= cpuAddr;
      sizeQ  <= cpuSize;
      weQ    <= cpuWe;
      wdataQ <= cpuWdata;
      mapQ   <= mapCfg;
    end
  end

  always_comb begin
    cfgAddr   = {mapQ[ADDR_W-1:0], addrQ};
    idsel     = cfgAddr[CFG_W-1:IDSEL_LSB];
    devNum    = lowestSet(idsel);
    type1     = mapQ[MAP_W-1];
    idselZero = (idsel == '0);
    mask      = widthMask(sizeQ);
    laneShift = {addrQ[1:0], 3'b000};
    case (sizeQ)
      SZ_BYTE: misalign = 1'b0;
      SZ_HALF: misalign = addrQ[0];
      default: misalign = |addrQ[1:0];
    endcase
    reject = type1 | idselZero | misalign;
  end

  assign dsAddr  = {1'b1, 7'b0, busNum, devNum, cfgAddr[10:8], cfgAddr[7:2], 2'b00};
  assign dsWdata = (wdataQ & mask) << laneShift;
  assign dsWe    = weQ;

  always_comb begin
    case (sizeQ)
      SZ_BYTE: dsByteEn = BE_W'(4'b0001) << addrQ[1:0];
      SZ_HALF: dsByteEn = BE_W'(4'b0011) << addrQ[1:0];
      default: dsByteEn = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdataQ <= '0;
      errQ   <= 1'b0;
    end else begin
      if (strb.rejLoad) begin
        rdataQ <= mask;
        if (idselZero && !type1) errQ <= 1'b1;
      end else if (strb.capRead) begin
        rdataQ <= (dsRdata >> laneShift) & mask;
      end
    end
  end

  assign rdata    = rdataQ;
  assign idselErr = errQ;

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errQ |=> errQ);

  a_r6_type1_keeps_err: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rejLoad && type1 && !errQ) |=> !errQ);
endmodule

// File: rtl/cfgx_ctrl.sv
module cfgx_ctrl
  import cfgx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cpuReq,
  input  logic    reject,
  input  logic    isWrite,
  input  logic    dsReady,
  output strobe_t strb,
  output logic    cpuReady,
  output logic    cpuDone,
  output logic    dsValid,
  output logic    clrPulse
);
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_RESP} state_t;
  state_t state, stateNxt;

  always_comb begin
    stateNxt     = state;
    strb         = '0;
    dsValid      = 1'b0;
    case (state)
      ST_IDLE: if (cpuReq) begin
        strb.load = 1'b1;
        stateNxt  = ST_ISSUE;
      end
      ST_ISSUE: begin
        if (reject) begin
          strb.rejLoad = 1'b1;
          stateNxt     = ST_RESP;
        end else begin
          dsValid = 1'b1;
          if (dsReady) stateNxt = isWrite ? ST_RESP : ST_WAIT;
        end
      end
      ST_WAIT: begin
        strb.capRead = 1'b1;
        stateNxt     = ST_RESP;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      clrPulse <= 1'b0;
    end else begin
      state    <= stateNxt;
      clrPulse <= dsValid && dsReady;
    end
  end

  assign cpuReady = (state == ST_IDLE);
  assign cpuDone  = (state == ST_RESP);

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |=> !cpuDone);

  a_r10_valid_hold: assert property (@(posedge clk) disable iff (!rstN)
    (dsValid && !dsReady) |=> dsValid);

  a_r9_clr_follows_hs: assert property (@(posedge clk) disable iff (!rstN)
    (dsValid && dsReady) |=> clrPulse);
endmodule

// File: rtl/cfg_window_xlate.sv
module cfg_window_xlate
  import cfgx_pkg::*;
#(
  parameter int STATUS_W   = 16,
  parameter int TABORT_BIT = 12,
  parameter int MABORT_BIT = 13
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cpuReq,
  input  logic                 cpuWe,
  input  logic [1:0]           cpuSize,
  input  logic [ADDR_W-1:0]    cpuAddr,
  input  logic [DATA_W-1:0]    cpuWdata,
  output logic                 cpuReady,
  output logic                 cpuDone,
  output logic [DATA_W-1:0]    cpuRdata,
  input  logic [MAP_W-1:0]     mapCfg,
  input  logic [BUS_W-1:0]     busNum,
  output logic                 idselErr,
  output logic [STATUS_W-1:0]  statusClr,
  output logic                 dsValid,
  output logic                 dsWe,
  output logic [CFG_W-1:0]     dsAddr,
  output logic [BE_W-1:0]      dsByteEn,
  output logic [DATA_W-1:0]    dsWdata,
  input  logic                 dsReady,
  input  logic [DATA_W-1:0]    dsRdata
);
  localparam logic [STATUS_W-1:0] ABORT_MASK =
    (STATUS_W'(1) << TABORT_BIT) | (STATUS_W'(1) << MABORT_BIT);

  strobe_t strb;
  logic    reject;
  logic    clrPulse;

  cfgx_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cpuReq   (cpuReq),
    .reject   (reject),
    .isWrite  (dsWe),
    .dsReady  (dsReady),
    .strb     (strb),
    .cpuReady (cpuReady),
    .cpuDone  (cpuDone),
    .dsValid  (dsValid),
    .clrPulse (clrPulse)
  );

  cfgx_dp dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cpuAddr  (cpuAddr),
    .cpuSize  (cpuSize),
    .cpuWe    (cpuWe),
    .cpuWdata (cpuWdata),
    .mapCfg   (mapCfg),
    .busNum   (busNum),
    .dsRdata  (dsRdata),
    .dsAddr   (dsAddr),
    .dsByteEn (dsByteEn),
    .dsWdata  (dsWdata),
    .dsWe     (dsWe),
    .rdata    (cpuRdata),
    .reject   (reject),
    .idselErr (idselErr)
  );

  assign statusClr = clrPulse ? ABORT_MASK : '0;

  a_r10_req_stable: assert property (@(posedge clk) disable iff (!rstN)
    (dsValid && !dsReady) |=> ($stable(dsAddr) && $stable(dsByteEn)));

  a_r3_be_shape: assert property (@(posedge clk) disable iff (!rstN)
    dsValid |-> ($countones(dsByteEn) == 1 || $countones(dsByteEn) == 2 ||
                 $countones(dsByteEn) == 4));

  a_r10_busy_while_issued: assert property (@(posedge clk) disable iff (!rstN)
    dsValid |-> !cpuReady);
endmodule

// File: tb/cfg_window_xlate_tb_top.sv
module cfg_window_xlate_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0;
  logic        cpuWe = 1'b0;
  logic [1:0]  cpuSize = 2'd0;
  logic [15:0] cpuAddr = '0;
  logic [31:0] cpuWdata = '0;
  logic        cpuReady, cpuDone;
  logic [31:0] cpuRdata;
  logic [16:0] mapCfg = '0;
  logic [7:0]  busNum = 8'h3C;
  logic        idselErr;
  logic [15:0] statusClr;
  logic        dsValid, dsWe;
  logic [31:0] dsAddr, dsWdata;
  logic [3:0]  dsByteEn;
  logic        dsReady = 1'b0;
  logic [31:0] dsRdata = '0;

  int total = 0;
  int bad = 0;
  logic errExp = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_window_xlate dut_i (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expAddr(input logic [16:0] m, input logic [15:0] a,
                                          input logic [7:0] b);
    logic [31:0] c;
    logic [4:0]  dev;
    c = {m[15:0], a};
    dev = '0;
    for (int i = 31; i >= 11; i--) if (c[i]) dev = 5'(i - 11);
    return {1'b1, 7'b0, b, dev, c[10:8], c[7:2], 2'b00};
  endfunction

  function automatic logic [31:0] maskOf(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [3:0] beOf(input logic [1:0] sz, input logic [1:0] a);
    return (sz == 2'd0) ? (4'b0001 << a) : (sz == 2'd1) ? (4'b0011 << a) : 4'b1111;
  endfunction

  task automatic checkReset();
    check(cpuReady === 1'b1, "R1 cpuReady", 32'(cpuReady), 32'd1);
    check(cpuDone === 1'b0 && dsValid === 1'b0, "R1 done/valid",
          {30'b0, cpuDone, dsValid}, 32'd0);
    check(idselErr === 1'b0, "R1 idselErr", 32'(idselErr), 32'd0);
    check(statusClr === 16'h0, "R1 statusClr", 32'(statusClr), 32'd0);
  endtask

  task automatic doAcc(input logic [16:0] m, input logic [15:0] a, input logic [1:0] sz,
                       input logic we, input logic [31:0] wd);
    bit fwd, idz, mis, clrBad, validSeen, holdBad;
    int hs, doneIter;
    logic [31:0] gotAddr, rdVal, expR;
    logic [3:0]  gotBe;
    logic [31:0] gotWd;
    logic        gotWe;
    @(negedge clk);
    mapCfg = m; cpuAddr = a; cpuSize = sz; cpuWe = we; cpuWdata = wd; cpuReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cpuReq = 1'b0;
    idz = ({m[15:0], a[15:11]} == 21'd0);
    mis = (sz == 2'd1) ? a[0] : (sz[1] ? (a[1:0] != 2'd0) : 1'b0);
    fwd = !m[16] && !idz && !mis;
    if (!m[16] && idz) errExp = 1'b1;
    hs = 0; doneIter = -1; clrBad = 0; validSeen = 0; holdBad = 0;
    gotAddr = '0; gotBe = '0; gotWd = '0; gotWe = 1'b0; rdVal = '0;
    for (int it = 0; it < 60; it++) begin
      if (statusClr !== (dsReady ? 16'h3000 : 16'h0)) clrBad = 1;
      if (dsReady) begin
        dsReady = 1'b0;
        hs++;
      end else if (dsValid) begin
        if (validSeen && (dsAddr !== gotAddr || dsByteEn !== gotBe)) holdBad = 1;
        validSeen = 1;
        gotAddr = dsAddr; gotBe = dsByteEn; gotWd = dsWdata; gotWe = dsWe;
        if ($urandom % 3 != 0) begin
          dsReady = 1'b1;
          rdVal = $urandom;
          dsRdata = rdVal;
        end
      end
      if (cpuDone) begin
        doneIter = it;
        break;
      end
      if (cpuReady && it > 0) holdBad = 1;
      @(negedge clk);
    end
    check(doneIter >= 0, "R11 done reached", 32'(doneIter), 32'd1);
    check(clrBad == 0, "R9 statusClr timing", 32'(statusClr), 32'h3000);
    check(holdBad == 0, "R10 hold/busy", gotAddr, gotAddr);
    if (fwd) begin
      check(hs == 1, "R2 one handshake", 32'(hs), 32'd1);
      check(gotAddr === expAddr(m, a, busNum), "R2 dsAddr", gotAddr, expAddr(m, a, busNum));
      check(gotBe === beOf(sz, a[1:0]), "R3 dsByteEn", 32'(gotBe), 32'(beOf(sz, a[1:0])));
      check(gotWe === we, "R4 dsWe", 32'(gotWe), 32'(we));
      if (we)
        check(gotWd === ((wd & maskOf(sz)) << {a[1:0], 3'b000}), "R4 dsWdata", gotWd,
              (wd & maskOf(sz)) << {a[1:0], 3'b000});
      else begin
        expR = (rdVal >> {a[1:0], 3'b000}) & maskOf(sz);
        check(cpuRdata === expR, "R5 cpuRdata", cpuRdata, expR);
      end
    end else begin
      check(!validSeen && hs == 0, m[16] ? "R6 no request" : (idz ? "R7 no request" : "R8 no request"),
            32'(validSeen), 32'd0);
      check(doneIter == 1, "R11 local done latency", 32'(doneIter), 32'd1);
      if (!we)
        check(cpuRdata === maskOf(sz), m[16] ? "R6 ones" : (idz ? "R7 ones" : "R8 ones"),
              cpuRdata, maskOf(sz));
    end
    @(negedge clk);
    check(cpuDone === 1'b0, "R11 single pulse", 32'(cpuDone), 32'd0);
    check(idselErr === errExp, "R7 idselErr", 32'(idselErr), 32'(errExp));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    checkReset();
    rstN = 1'b1;
    @(negedge clk);
    checkReset();

    // directed: lowest IDSEL bit (device 0) and highest (device 20)
    doAcc(17'h00000, 16'h0904, 2'd2, 1'b0, 32'h0);
    doAcc(17'h08000, 16'h0000, 2'd2, 1'b1, 32'hCAFE_F00D);
    // directed: multi-hot select picks lowest set bit
    doAcc(17'h00120, 16'h3000, 2'd0, 1'b0, 32'h0);
    // directed R6: type-1 reads of each width, and a dropped write
    doAcc(17'h10040, 16'h0001, 2'd0, 1'b0, 32'h0);
    doAcc(17'h10040, 16'h0002, 2'd1, 1'b0, 32'h0);
    doAcc(17'h10040, 16'h0000, 2'd2, 1'b0, 32'h0);
    doAcc(17'h10040, 16'h0000, 2'd2, 1'b1, 32'h1234_5678);
    // directed R8: misaligned halfword and word
    doAcc(17'h00040, 16'h0003, 2'd1, 1'b0, 32'h0);
    doAcc(17'h00040, 16'h0002, 2'd3, 1'b0, 32'h0);
    // type-1 with zero select: no error
    doAcc(17'h10000, 16'h0000, 2'd0, 1'b0, 32'h0);
    // byte lanes
    for (int l = 0; l < 4; l++) doAcc(17'h00002, 16'(l), 2'd0, 1'b1, 32'hA5C3_96E1);
    doAcc(17'h00002, 16'h0002, 2'd1, 1'b0, 32'h0);

    for (int n = 0; n < 300; n++) begin
      logic [16:0] m;
      logic [15:0] a;
      logic [1:0]  sz;
      m = {($urandom % 10 == 0), 16'($urandom)};
      if ($urandom % 4 == 0) m[15:0] = 16'(1) << ($urandom % 16);
      a = 16'($urandom);
      sz = 2'($urandom);
      if ($urandom % 5 != 0) a[1:0] = sz[1] ? 2'b00 : (sz[0] ? {a[1], 1'b0} : a[1:0]);
      doAcc(m, a, sz, 1'($urandom), $urandom);
    end

    // directed R7: zero select sets sticky flag, later good access keeps it
    doAcc(17'h00000, 16'h07FC, 2'd2, 1'b0, 32'h0);
    doAcc(17'h00001, 16'h0010, 2'd2, 1'b0, 32'h0);

    // reset clears state again
    @(negedge clk);
    rstN = 1'b0;
    errExp = 1'b0;
    @(negedge clk);
    checkReset();
    rstN = 1'b1;
    doAcc(17'h00400, 16'h0108, 2'd1, 1'b0, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule